// File: doc/BRIEF.md
# Audio Master-Mode Serial Clock Generator

This block acts as the clock master of a stereo audio serial port. From a reference clock running at twice the master clock (MCLK) rate it produces a bit clock at 64 times the sample rate and a frame clock at the sample rate. Each half-frame holds 32 bit-clock periods, and the frame clock changes level only on a bit-clock falling edge. Because the reference runs at twice the MCLK rate, the fractional 1.5 pre-divide becomes a whole number of reference cycles. Every ratio is then a plain counter wrap.

Two configuration fields set the clocks. A 3-bit field selects an MCLK pre-divide of 1, 1.5, 2, 3 or 4. A 2-bit field selects single, double or quad speed, which sets the bit-clock divide to 4, 2 or 1. The resulting MCLK-to-frame ratio runs from 64 to 1024 and includes 384 and 768. Any change to either field restarts both clocks from a known phase. Reserved codes park both clocks low. The block also emits a free-running one-cycle enable at the MCLK rate.

Top module: `aud_master_clkgen`

## Requirements
- R1: Pre-divide codes 0, 1, 2, 3 and 4 select an MCLK divide of 1, 1.5, 2, 3 and 4. The bit-clock period in reference cycles is twice the pre-divide times the speed divide.
- R2: Speed codes 0, 1 and 2 select a bit-clock divide of 4, 2 and 1 after the pre-divide. The frame is always 64 bit-clock periods.
- R3: The frame clock toggles only at a bit-clock falling edge, once every 32 bit-clock periods. After a restart its first toggle comes at reference cycle 32 times the bit-clock period.
- R4: Within each bit-clock period the clock is low for ceil(P/2) reference cycles and then high for floor(P/2), where P is the period. An odd period of 3 therefore gives 2 cycles low and 1 cycle high.
- R5: Pre-divide codes 5 to 7, or speed code 3, hold the bit clock and the frame clock low.
- R6: One cycle after either field changes, the bit clock and the frame clock are low. Counting then restarts exactly as after reset.
- R7: During and right after reset, the frame clock, the bit clock and the MCLK enable are low.
- R8: The MCLK enable is low in the first cycle after reset and then alternates every reference cycle, whatever the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at twice the MCLK rate |
| rst | input | 1 | Synchronous active-high reset |
| pre_sel | input | 3 | MCLK pre-divide select |
| spd_sel | input | 2 | Speed mode select |
| lrck | output | 1 | Frame clock, low for the left channel |
| sclk | output | 1 | Bit clock at 64 times the sample rate |
| mclk_en | output | 1 | One-cycle pulse at the MCLK rate |

## Verification
The hardest case to reach is a frame-clock toggle at the far end of a long frame. With pre-divide 4 at single speed, the first toggle comes 1024 reference cycles after a restart. The combined pre-divide and speed divide must also be right at that point. The stimulus sweeps all fifteen legal pairs and runs each for two full frames, so both frame-clock edges are seen for every ratio, including the odd 3-cycle bit-clock period. It also switches configuration while the frame clock is high, to show the restart pulling it low in mid-frame.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
  localparam int PRE_W = 3;
  localparam int SPD_W = 2;
  localparam int CFG_W = PRE_W + SPD_W;

  typedef enum logic [SPD_W-1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } spd_mode_e;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SPD_W-1:0] spd;
  } clk_cfg_t;
endpackage

// File: rtl/aud_clk_cfg.sv
module aud_clk_cfg #(
  parameter int CNT_W = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [aud_clk_pkg::PRE_W-1:0] pre_sel,
  input  logic [aud_clk_pkg::SPD_W-1:0] spd_sel,
  output logic                          restart,
  output logic                          valid,
  output logic [CNT_W-1:0]              period,
  output logic [CNT_W-1:0]              lo_len
);
  import aud_clk_pkg::*;

  clk_cfg_t cfg_q;
  clk_cfg_t cfg_in;
  logic [CNT_W-1:0] pre_x2;
  logic [1:0]       shamt;
  logic             pre_ok;
  logic             spd_ok;

  assign cfg_in = '{pre: pre_sel, spd: spd_sel};

  always_ff @(posedge clk) begin
    cfg_q <= cfg_in;
  end

  assign restart = !rst && (cfg_in != cfg_q);

  // Pre-divide in reference half-MCLK units: 1 -> 2, 1.5 -> 3, 2 -> 4, 3 -> 6, 4 -> 8
  always_comb begin
    pre_ok = 1'b1;
    case (cfg_q.pre)
      3'd0:    pre_x2 = CNT_W'(2);
      3'd1:    pre_x2 = CNT_W'(3);
      3'd2:    pre_x2 = CNT_W'(4);
      3'd3:    pre_x2 = CNT_W'(6);
      3'd4:    pre_x2 = CNT_W'(8);
      default: begin pre_x2 = CNT_W'(2); pre_ok = 1'b0; end
    endcase
  end

  always_comb begin
    spd_ok = 1'b1;
    case (spd_mode_e'(cfg_q.spd))
      SPD_SINGLE: shamt = 2'd2;
      SPD_DOUBLE: shamt = 2'd1;
      SPD_QUAD:   shamt = 2'd0;
      default:    begin shamt = 2'd0; spd_ok = 1'b0; end
    endcase
  end

  assign valid  = pre_ok && spd_ok;
  assign period = pre_x2 << shamt;
  assign lo_len = CNT_W'((period + CNT_W'(1)) >> 1);

  assert_period_range_R1: assert property (@(posedge clk) disable iff (rst)
    valid |-> (period >= CNT_W'(2) && period <= CNT_W'(32)));
endmodule

// File: rtl/aud_clk_bitdiv.sv
module aud_clk_bitdiv #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             valid,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] lo_len,
  output logic             sclk,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             last;
  logic             run;

  assign run     = valid && !restart;
  assign last    = (cnt == period - CNT_W'(1));
  assign cnt_nxt = last ? '0 : cnt + CNT_W'(1);
  assign wrap    = run && last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      sclk <= (cnt_nxt >= lo_len);
    end
  end

  assert_cnt_inside_R1: assert property (@(posedge clk) disable iff (rst)
    valid |-> cnt < period);
  assert_restart_clears_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !sclk));
  assert_rsvd_sclk_low_R5: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !sclk);
endmodule

// File: rtl/aud_clk_frame.sv
module aud_clk_frame #(
  parameter int HALF_BITS = 32,
  localparam int BC_W = $clog2(HALF_BITS)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic valid,
  input  logic wrap,
  output logic lrck
);
  logic [BC_W-1:0] bc;
  logic            bc_last;

  assign bc_last = (bc == BC_W'(HALF_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !valid) begin
      bc   <= '0;
      lrck <= 1'b0;
    end else if (wrap) begin
      bc <= bc_last ? '0 : bc + BC_W'(1);
      if (bc_last) lrck <= ~lrck;
    end
  end

  assert_bc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && !restart && !wrap) |=> $stable(bc));
  assert_rsvd_lrck_low_R5: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !lrck);
endmodule

// File: rtl/aud_master_clkgen.sv
module aud_master_clkgen #(
  parameter int CNT_W     = 6,
  parameter int HALF_BITS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] pre_sel,
  input  logic [1:0] spd_sel,
  output logic       lrck,
  output logic       sclk,
  output logic       mclk_en
);
  logic             restart;
  logic             valid;
  logic             wrap;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] lo_len;
  logic             ph;

  aud_clk_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .pre_sel(pre_sel), .spd_sel(spd_sel),
    .restart(restart), .valid(valid), .period(period), .lo_len(lo_len)
  );

  aud_clk_bitdiv #(.CNT_W(CNT_W)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .valid(valid),
    .period(period), .lo_len(lo_len), .sclk(sclk), .wrap(wrap)
  );

  aud_clk_frame #(.HALF_BITS(HALF_BITS)) u_frm (
    .clk(clk), .rst(rst), .restart(restart), .valid(valid),
    .wrap(wrap), .lrck(lrck)
  );

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end
  assign mclk_en = ph;

  assert_lrck_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (lrck != $past(lrck) && !$past(restart) && !$past(rst)) |-> $fell(sclk));
  assert_mclk_alt_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (mclk_en != $past(mclk_en)));
  assert_change_low_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!lrck && !sclk));
endmodule

// File: tb/tb_aud_master_clkgen.sv
module tb_aud_master_clkgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] pre_sel = 3'd0;
  logic [1:0] spd_sel = 2'd0;
  logic       lrck, sclk, mclk_en;

  int n_chk = 0;
  int n_bad = 0;
  int n = 0;
  int m = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aud_master_clkgen dut (
    .clk(clk), .rst(rst), .pre_sel(pre_sel), .spd_sel(spd_sel),
    .lrck(lrck), .sclk(sclk), .mclk_en(mclk_en)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b (n=%0d m=%0d pre=%0d spd=%0d)",
               tag, what, got, exp, n, m, pre_sel, spd_sel);
    end
  endtask

  function automatic int pre_x2(input int p);
    case (p)
      0: return 2; 1: return 3; 2: return 4; 3: return 6; 4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int spd_div(input int s);
    case (s)
      0: return 4; 1: return 2; 2: return 1;
      default: return 0;
    endcase
  endfunction

  // Called at a negedge; checks the current state, then advances one edge.
  task automatic run(input int ncyc, input int per, input bit ok, input string tag);
    for (int i = 0; i < ncyc; i++) begin
      if (ok) begin
        chk(tag, "sclk", sclk, ((n % per) >= ((per + 1) / 2)));
        chk("R3", "lrck", lrck, ((n / (32 * per)) % 2) == 1);
      end else begin
        chk("R5", "sclk", sclk, 1'b0);
        chk("R5", "lrck", lrck, 1'b0);
      end
      chk("R8", "mclk_en", mclk_en, (m % 2) == 1);
      @(posedge clk); n++; m++;
      @(negedge clk);
    end
  endtask

  task automatic apply(input int p, input int s);
    pre_sel = 3'(p);
    spd_sel = 2'(s);
    @(posedge clk); n = 0; m++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", "lrck", lrck, 1'b0);
    chk("R7", "sclk", sclk, 1'b0);
    chk("R7", "mclk_en", mclk_en, 1'b0);
    rst = 1'b0;
    n = 0; m = 0;
    run(8, 8, 1'b1, "R7");

    // Mid-frame change while lrck is high
    run(300, 8, 1'b1, "R1");
    chk("R6", "lrck before change", lrck, 1'b1);
    apply(0, 1);
    chk("R6", "lrck after change", lrck, 1'b0);
    chk("R6", "sclk after change", sclk, 1'b0);
    run(64 * 4 + 7, 4, 1'b1, "R6");

    // Full sweep of legal settings, two frames each
    for (int p = 0; p < 5; p++) begin
      for (int s = 0; s < 3; s++) begin
        int per;
        per = pre_x2(p) * spd_div(s);
        apply(p, s);
        run(128 * per + 3, per, 1'b1, (per == 3) ? "R4" : ((s == 0) ? "R1" : "R2"));
      end
    end

    // Reserved codes
    for (int p = 5; p < 8; p++) begin
      apply(p, 0);
      run(40, 1, 1'b0, "R5");
    end
    apply(0, 3);
    run(40, 1, 1'b0, "R5");
    apply(2, 0);
    run(600, 16, 1'b1, "R6");

    // Reset mid-run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", "lrck in reset", lrck, 1'b0);
    chk("R7", "sclk in reset", sclk, 1'b0);
    chk("R7", "mclk_en in reset", mclk_en, 1'b0);
    rst = 1'b0;
    n = 0; m = 0;
    run(40, 16, 1'b1, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule